// File: doc/BRIEF.md
# Configurable GPIO Port Register Bank

This block is the register side of a general purpose I/O port. It keeps three writable bytes: an output latch, a per-bit polarity mask, and a direction mask. It also provides one read-only view of the synchronized pin levels. A host writes a byte by asserting a write strobe together with a register select and the data. The bank returns the selected register on a combinational read bus. The same select signal addresses both reads and writes.

Each pin has a drive value and a drive enable toward the pad logic. The direction mask sets the enable directly. The latch value reaches the pad only for pins that are set as outputs. Pin levels pass through a synchronizer chain before they can be read. The polarity mask acts only on the value that is read back; it never acts on the pins. The serial front end, the pad drivers and any change-detect interrupt sit outside this block.

Top module: `gpio_regbank`

## Requirements
- R1: After reset the output latch reads 0xFF, the polarity mask reads 0x00 and the direction mask reads 0xFF, so every `pin_oe` bit is 0 and every `pin_out` bit is 0.
- R2: `reg_sel` encodes 0 = pin level view, 1 = output latch, 2 = polarity mask, 3 = direction mask. `rd_data` shows the selected register combinationally. A write with `wr_en` high changes the selected register at that rising edge.
- R3: A write with `reg_sel` = 0 has no effect: the latch, the polarity mask, the direction mask, `pin_oe` and `pin_out` all keep their values.
- R4: The pin level view reports the synchronized `pin_in` level for every bit, including bits that are driven as outputs.
- R5: Reading with `reg_sel` = 0 returns the synchronized pin level XOR the polarity mask: a 1 in mask bit n inverts bit n, and a 0 leaves it as it is.
- R6: Reading with `reg_sel` = 1 returns the stored latch value, whatever the pins carry.
- R7: `pin_oe[n]` is the inverse of direction bit n, where 1 means input and 0 means output. It changes at the same edge that writes the direction mask.
- R8: `pin_out[n]` equals latch bit n when the pin is an output, and it is 0 when the pin is an input.
- R9: A change on `pin_in` becomes visible in the pin level view after exactly two rising edges (SYNC_STAGES = 2). After one edge the view still shows the old level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the selected register |
| reg_sel | input | 2 | Register select for read and write |
| wr_data | input | WIDTH | Write data byte |
| rd_data | output | WIDTH | Read data of the selected register |
| pin_in | input | WIDTH | Pin levels from the pads (asynchronous) |
| pin_out | output | WIDTH | Drive value toward the pads |
| pin_oe | output | WIDTH | Per-pin drive enable, 1 = driven |

## Verification
Two effects can land in the same cycle. A pin-level change can reach the read path through the synchronizer in the cycle a new polarity mask is written, and a direction write can flip a pin from input to output while the latch already holds a value. The bench sweeps every polarity value and changes `pin_in` in the same cycle as each mask write. After the synchronizer delay it expects pin XOR mask. It also sweeps every direction value over a fixed latch and judges `pin_oe` and `pin_out` against the inverted mask and the masked latch, computed arithmetically.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;
   localparam int SEL_BITS = 2;
   typedef enum logic [SEL_BITS-1:0] {
      SEL_PINS = 2'd0,
      SEL_LATCH = 2'd1,
      SEL_POLAR = 2'd2,
      SEL_DIR   = 2'd3
   } gpio_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk) chain[0] <= d;

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk) chain[s] <= chain[s-1];
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
   import gpio_regbank_pkg::*;
#(
   parameter int               WIDTH     = 8,
   parameter logic [WIDTH-1:0] LATCH_RST = '1,
   parameter logic [WIDTH-1:0] POLAR_RST = '0,
   parameter logic [WIDTH-1:0] DIR_RST   = '1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [SEL_BITS-1:0] sel,
   input  logic [WIDTH-1:0]    wdata,
   output logic [WIDTH-1:0]    latch_q,
   output logic [WIDTH-1:0]    polar_q,
   output logic [WIDTH-1:0]    dir_q
);
   gpio_sel_e sel_e;
   logic      we_latch, we_polar, we_dir;

   assign sel_e    = gpio_sel_e'(sel);
   assign we_latch = wr_en && (sel_e == SEL_LATCH);
   assign we_polar = wr_en && (sel_e == SEL_POLAR);
   assign we_dir   = wr_en && (sel_e == SEL_DIR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= LATCH_RST;
         polar_q <= POLAR_RST;
         dir_q   <= DIR_RST;
      end else begin
         if (we_latch) latch_q <= wdata;
         if (we_polar) polar_q <= wdata;
         if (we_dir)   dir_q   <= wdata;
      end
   end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
   import gpio_regbank_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [SEL_BITS-1:0] sel,
   input  logic [WIDTH-1:0]    pins_sync,
   input  logic [WIDTH-1:0]    latch_q,
   input  logic [WIDTH-1:0]    polar_q,
   input  logic [WIDTH-1:0]    dir_q,
   output logic [WIDTH-1:0]    rdata
);
   logic [WIDTH-1:0] pin_view;

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_inv
         assign pin_view[b] = pins_sync[b] ^ polar_q[b];
      end
   endgenerate

   always_comb begin
      unique case (gpio_sel_e'(sel))
         SEL_PINS:  rdata = pin_view;
         SEL_LATCH: rdata = latch_q;
         SEL_POLAR: rdata = polar_q;
         SEL_DIR:   rdata = dir_q;
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
   import gpio_regbank_pkg::*;
#(
   parameter int               WIDTH       = 8,
   parameter int               SYNC_STAGES = 2,
   parameter logic [WIDTH-1:0] LATCH_RST   = '1,
   parameter logic [WIDTH-1:0] POLAR_RST   = '0,
   parameter logic [WIDTH-1:0] DIR_RST     = '1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [SEL_BITS-1:0] reg_sel,
   input  logic [WIDTH-1:0]    wr_data,
   output logic [WIDTH-1:0]    rd_data,
   input  logic [WIDTH-1:0]    pin_in,
   output logic [WIDTH-1:0]    pin_out,
   output logic [WIDTH-1:0]    pin_oe
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("gpio_regbank: WIDTH must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_regbank: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] pins_sync;
   logic [WIDTH-1:0] latch_q, polar_q, dir_q;

   gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .d   (pin_in),
      .q   (pins_sync)
   );

   gpio_cfg_regs #(
      .WIDTH(WIDTH), .LATCH_RST(LATCH_RST),
      .POLAR_RST(POLAR_RST), .DIR_RST(DIR_RST)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .sel     (reg_sel),
      .wdata   (wr_data),
      .latch_q (latch_q),
      .polar_q (polar_q),
      .dir_q   (dir_q)
   );

   gpio_read_mux #(.WIDTH(WIDTH)) u_rmux (
      .sel       (reg_sel),
      .pins_sync (pins_sync),
      .latch_q   (latch_q),
      .polar_q   (polar_q),
      .dir_q     (dir_q),
      .rdata     (rd_data)
   );

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_pad
         assign pin_oe[b]  = ~dir_q[b];
         assign pin_out[b] = dir_q[b] ? 1'b0 : latch_q[b];
      end
   endgenerate
endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk #(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       reg_sel,
   input logic [WIDTH-1:0] wr_data,
   input logic [WIDTH-1:0] rd_data,
   input logic [WIDTH-1:0] pin_in,
   input logic [WIDTH-1:0] pin_out,
   input logic [WIDTH-1:0] pin_oe,
   input logic [WIDTH-1:0] latch_q,
   input logic [WIDTH-1:0] polar_q,
   input logic [WIDTH-1:0] dir_q
);
   assert_reset_vals_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (latch_q == '1 && polar_q == '0 && dir_q == '1 && pin_oe == '0));

   assert_pinview_wr_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_sel == 2'd0) |=> ($stable(latch_q) && $stable(polar_q) && $stable(dir_q)));

   assert_latch_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_sel == 2'd1) |=> (latch_q == $past(wr_data)));

   assert_oe_follows_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_sel == 2'd3) |=> (pin_oe == ~$past(wr_data)));

   assert_input_pins_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & ~pin_oe) == '0);

   generate
      if (SYNC_STAGES == 2) begin : g_view
         assert_pin_view_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_sel == 2'd0) |-> (rd_data == ($past(pin_in, 2) ^ polar_q)));
      end
   endgenerate
endmodule

bind gpio_regbank gpio_regbank_chk #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .reg_sel (reg_sel),
   .wr_data (wr_data),
   .rd_data (rd_data),
   .pin_in  (pin_in),
   .pin_out (pin_out),
   .pin_oe  (pin_oe),
   .latch_q (latch_q),
   .polar_q (polar_q),
   .dir_q   (dir_q)
);

// File: tb/gpio_regbank_tb.sv
`timescale 1ns/1ps
module gpio_regbank_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] reg_sel = 2'd0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic [7:0] pin_in = 8'h00;
   logic [7:0] pin_out, pin_oe;

   int vecs = 0;
   int errs = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   gpio_regbank u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
      .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; reg_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [1:0] sel, input logic [7:0] exp);
      reg_sel = sel;
      #0.5;
      check(req, rd_data, exp);
   endtask

   initial begin
      #800000;
      if (!done) begin
         errs++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset values
      rd_check("R1 latch", 2'd1, 8'hFF);
      rd_check("R1 polar", 2'd2, 8'h00);
      rd_check("R1 dir",   2'd3, 8'hFF);
      check("R1 oe",  pin_oe,  8'h00);
      check("R1 out", pin_out, 8'h00);

      // R9 synchronizer latency
      @(negedge clk);
      pin_in = 8'hA7;
      reg_sel = 2'd0;
      @(negedge clk);
      #0.5 check("R9 one edge", rd_data, 8'h00);
      @(negedge clk);
      #0.5 check("R9 two edges", rd_data, 8'hA7);

      // R5/R2 polarity sweep; pin change lands in the same cycle as the mask write
      for (int v = 0; v < 256; v++) begin
         logic [7:0] p;
         p = 8'((v * 37) ^ 8'h3C);
         @(negedge clk);
         pin_in = p;
         wr(2'd2, 8'(v));
         rd_check("R2 polar readback", 2'd2, 8'(v));
         @(negedge clk);
         rd_check("R5 inverted view", 2'd0, p ^ 8'(v));
      end
      wr(2'd2, 8'h00);

      // R7/R8 direction sweep over a fixed latch
      wr(2'd1, 8'hC3);
      for (int v = 0; v < 256; v++) begin
         wr(2'd3, 8'(v));
         #0.5;
         check("R7 oe", pin_oe, ~8'(v));
         check("R8 out", pin_out, 8'hC3 & ~8'(v));
         rd_check("R2 dir readback", 2'd3, 8'(v));
      end

      // R6/R4 latch sweep with all pins driven and the pins disagreeing
      wr(2'd3, 8'h00);
      for (int v = 0; v < 256; v++) begin
         @(negedge clk);
         pin_in = ~8'(v);
         wr(2'd1, 8'(v));
         @(negedge clk);
         rd_check("R6 latch not pin", 2'd1, 8'(v));
         rd_check("R4 pin on output", 2'd0, ~8'(v));
         check("R8 driven", pin_out, 8'(v));
      end

      // R3 writes to the pin view are dropped
      wr(2'd1, 8'h96);
      wr(2'd2, 8'h0F);
      wr(2'd3, 8'h55);
      for (int v = 0; v < 4; v++) begin
         wr(2'd0, 8'(v * 85));
         rd_check("R3 latch kept", 2'd1, 8'h96);
         rd_check("R3 polar kept", 2'd2, 8'h0F);
         rd_check("R3 dir kept",   2'd3, 8'h55);
         check("R3 oe kept",  pin_oe,  8'hAA);
         check("R3 out kept", pin_out, 8'h82);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule